// File: doc/BRIEF.md
# Register-Mapped 24-Pin GPIO Expander Core

This block holds the register file and pin-control logic of a 24-pin general-purpose I/O expander. A byte-wide register bus (8-bit address, 8-bit write data, write and read strobes, registered 8-bit read data) configures each pin. Pins 0-15 form the primary bank and pins 16-23 the alternate bank. Every per-pin function spans three consecutive byte registers, with pin n at byte n/8, bit n%8. On the pad side each pin has an output value, an output enable, a pull enable, a pull polarity and a raw input.

Output levels change only through write-one-to-set and write-one-to-clear registers. Each bank is gated by its own enable bit. An identity register reads as the complement of the device bus address chosen by an address-select input. A software reset request moves a two-state controller from `ST_RUN` to `ST_BOOT`. `ST_BOOT` lasts a parameterised number of cycles, during which the device ignores writes and reads back zero. The transition `ST_BOOT` to `ST_RUN` happens when the count expires and clears every configuration register.

Top module: `pinx_core`

## Requirements
- R1: After reset every pad has output enable 0, pull enable 0 and pull-up 0, and the system control (0x40) and direction (0x60) registers read 0x00.
- R2: Address 0x00 reads the complement of the bus address {6'b100001, addr_sel, 1'b0}: 0x7B when addr_sel is 0 and 0x79 when it is 1. Addresses 0x01 and 0x02 read the firmware version high and low bytes. Read data appears on the clock edge that samples the read strobe.
- R3: Direction registers 0x60-0x62 set a pin to input with 0 and to output with 1. An output pin whose drive-type bit (0x64-0x66) is 1 is push-pull: output enable 1, pad output equal to its latch.
- R4: Writing 1s to 0x6C-0x6E sets latch bits and writing 1s to 0x70-0x72 clears them. Zero bits leave the latch unchanged. Reading either register range returns the latch.
- R5: An output pin with drive-type bit 0 is open-drain: its output enable is 1 only while its latch is 0.
- R6: An input pin with drive-type bit 1 has pull enable 1, and its pull-up equals its pull-select bit (0x68-0x6A, 1 = up, 0 = down). With drive-type 0 it floats: pull enable 0. An input pin never has output enable 1.
- R7: Raw pad inputs pass two synchroniser flops before they appear in 0x10-0x12. A change made just before a read is not seen by that read but is seen by the next read.
- R8: System control bit 0 enables the primary bank and bit 3 the alternate bank. While a bank is disabled its pins have output enable 0 and pull enable 0, and writes to its bytes in the per-pin registers have no effect.
- R9: Writing 0x40 with bit 7 set enters `ST_BOOT` for BOOT_CYCLES cycles. During that time reads return 0x00 and writes are ignored. On return to `ST_RUN` all configuration and latch registers are zero and both banks are disabled.
- R10: Writes to read-only addresses (0x00-0x02, 0x10-0x12) and to unmapped addresses are ignored. Reads from unmapped addresses (such as 0x50 or 0x63) return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 1 | Bus address select, chooses 0x84 or 0x86 |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 24 | Raw pin inputs |
| pad_out | output | 24 | Pin output values |
| pad_oe | output | 24 | Pin output enables |
| pad_pull_en | output | 24 | Pull resistor enables |
| pad_pull_up | output | 24 | Pull polarity, 1 = up |

## Verification
The hardest situation to reach is the proof that writes to a disabled bank were dropped. While the bank is off its pads are forced to a neutral state, so the outputs cannot show whether the write landed. The stimulus first configures pulls on the alternate bank and then disables it. It then writes a clearing value to that bank's drive-type byte and re-enables the bank, and the original pulls must reappear. The software-reset window is reached the same way: the bench issues a read and a write inside `ST_BOOT` and checks the result after the count expires.

// File: rtl/pinx_pkg.sv
package pinx_pkg;
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_BOOT = 1'b1
    } pinx_state_t;

    localparam logic [7:0] A_IDENT  = 8'h00;
    localparam logic [7:0] A_FW_HI  = 8'h01;
    localparam logic [7:0] A_FW_LO  = 8'h02;
    localparam logic [7:0] A_SYSCTL = 8'h40;

    // address[7:2] of each three-byte per-pin group
    localparam logic [5:0] G_IN  = 6'h04;
    localparam logic [5:0] G_DIR = 6'h18;
    localparam logic [5:0] G_TYP = 6'h19;
    localparam logic [5:0] G_PUL = 6'h1A;
    localparam logic [5:0] G_SET = 6'h1B;
    localparam logic [5:0] G_CLR = 6'h1C;
endpackage

// File: rtl/pinx_sync.sv
module pinx_sync #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pinx_fsm.sv
module pinx_fsm
    import pinx_pkg::*;
#(
    parameter int BOOT_CYCLES = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic busy,
    output logic boot_done
);
    localparam int CW = $clog2(BOOT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(BOOT_CYCLES - 1);

    pinx_state_t st, st_nxt;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_RUN;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= (st == ST_BOOT && st_nxt == ST_BOOT) ? cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        st_nxt    = st;
        busy      = 1'b0;
        boot_done = 1'b0;
        unique case (st)
            ST_RUN: begin
                if (req) st_nxt = ST_BOOT;
            end
            ST_BOOT: begin
                busy = 1'b1;
                if (cnt == LAST) begin
                    boot_done = 1'b1;
                    st_nxt    = ST_RUN;
                end
            end
            default: st_nxt = ST_RUN;
        endcase
    end
endmodule

// File: rtl/pinx_regs.sv
module pinx_regs
    import pinx_pkg::*;
#(
    parameter int NPIN = 24,
    parameter int PRI_PINS = 16,
    parameter logic [7:0] FW_HI = 8'h01,
    parameter logic [7:0] FW_LO = 8'h10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            addr_sel,
    input  logic [7:0]      bus_addr,
    input  logic [7:0]      bus_wdata,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic            busy,
    input  logic            boot_done,
    input  logic [NPIN-1:0] in_sync,
    output logic [7:0]      bus_rdata,
    output logic            pri_en,
    output logic            alt_en,
    output logic [NPIN-1:0] dir,
    output logic [NPIN-1:0] typ,
    output logic [NPIN-1:0] pul,
    output logic [NPIN-1:0] lat
);
    localparam int NBYTE = NPIN / 8;

    logic       rst_req;
    logic [5:0] grp;
    logic [1:0] idx;
    logic       idx_ok;
    logic [NBYTE-1:0] bank_ok;
    logic [7:0] rd_val;
    logic [7:0] dev_addr;

    assign grp      = bus_addr[7:2];
    assign idx      = bus_addr[1:0];
    assign idx_ok   = (32'(idx) < NBYTE);
    assign dev_addr = {6'b100001, addr_sel, 1'b0};

    for (genvar b = 0; b < NBYTE; b++) begin : g_bank
        if (b * 8 < PRI_PINS) begin : g_pri
            assign bank_ok[b] = pri_en;
        end else begin : g_alt
            assign bank_ok[b] = alt_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {rst_req, alt_en, pri_en} <= '0;
            dir <= '0; typ <= '0; pul <= '0; lat <= '0;
        end else if (boot_done) begin
            {rst_req, alt_en, pri_en} <= '0;
            dir <= '0; typ <= '0; pul <= '0; lat <= '0;
        end else if (bus_wr && !busy) begin
            if (bus_addr == A_SYSCTL) begin
                rst_req <= bus_wdata[7];
                alt_en  <= bus_wdata[3];
                pri_en  <= bus_wdata[0];
            end else begin
                for (int b = 0; b < NBYTE; b++) begin
                    if (32'(idx) == b && bank_ok[b]) begin
                        case (grp)
                            G_DIR: dir[b*8 +: 8] <= bus_wdata;
                            G_TYP: typ[b*8 +: 8] <= bus_wdata;
                            G_PUL: pul[b*8 +: 8] <= bus_wdata;
                            G_SET: lat[b*8 +: 8] <= lat[b*8 +: 8] | bus_wdata;
                            G_CLR: lat[b*8 +: 8] <= lat[b*8 +: 8] & ~bus_wdata;
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    always_comb begin
        rd_val = 8'h00;
        case (bus_addr)
            A_IDENT:  rd_val = ~dev_addr;
            A_FW_HI:  rd_val = FW_HI;
            A_FW_LO:  rd_val = FW_LO;
            A_SYSCTL: rd_val = {rst_req, 3'b000, alt_en, 2'b00, pri_en};
            default: begin
                if (idx_ok) begin
                    case (grp)
                        G_IN:          rd_val = 8'(in_sync >> (8 * 32'(idx)));
                        G_DIR:         rd_val = 8'(dir >> (8 * 32'(idx)));
                        G_TYP:         rd_val = 8'(typ >> (8 * 32'(idx)));
                        G_PUL:         rd_val = 8'(pul >> (8 * 32'(idx)));
                        G_SET, G_CLR:  rd_val = 8'(lat >> (8 * 32'(idx)));
                        default:       rd_val = 8'h00;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= 8'h00;
        else if (bus_rd) bus_rdata <= busy ? 8'h00 : rd_val;
    end
endmodule

// File: rtl/pinx_pad.sv
module pinx_pad #(
    parameter int NPIN = 24
) (
    input  logic [NPIN-1:0] en,
    input  logic [NPIN-1:0] dir,
    input  logic [NPIN-1:0] typ,
    input  logic [NPIN-1:0] pul,
    input  logic [NPIN-1:0] lat,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_pull_en,
    output logic [NPIN-1:0] pad_pull_up
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        always_comb begin
            pad_out[i]     = en[i] & lat[i];
            pad_oe[i]      = 1'b0;
            pad_pull_en[i] = 1'b0;
            pad_pull_up[i] = 1'b0;
            if (en[i]) begin
                if (dir[i]) begin
                    // push-pull drives always, open-drain only pulls low
                    pad_oe[i] = typ[i] | ~lat[i];
                end else begin
                    pad_pull_en[i] = typ[i];
                    pad_pull_up[i] = typ[i] & pul[i];
                end
            end
        end
    end
endmodule

// File: rtl/pinx_core.sv
module pinx_core
    import pinx_pkg::*;
#(
    parameter int PRI_PINS = 16,
    parameter int ALT_PINS = 8,
    parameter int BOOT_CYCLES = 2000000,
    parameter logic [7:0] FW_HI = 8'h01,
    parameter logic [7:0] FW_LO = 8'h10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        addr_sel,
    input  logic [7:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_wr,
    input  logic        bus_rd,
    output logic [7:0]  bus_rdata,
    input  logic [PRI_PINS+ALT_PINS-1:0] pad_in,
    output logic [PRI_PINS+ALT_PINS-1:0] pad_out,
    output logic [PRI_PINS+ALT_PINS-1:0] pad_oe,
    output logic [PRI_PINS+ALT_PINS-1:0] pad_pull_en,
    output logic [PRI_PINS+ALT_PINS-1:0] pad_pull_up
);
    localparam int NPIN = PRI_PINS + ALT_PINS;

    logic busy, boot_done, req;
    logic pri_en, alt_en;
    logic [NPIN-1:0] in_sync, dir, typ, pul, lat, en_vec;

    assign req    = bus_wr && (bus_addr == A_SYSCTL) && bus_wdata[7];
    assign en_vec = {{ALT_PINS{alt_en}}, {PRI_PINS{pri_en}}};

    pinx_sync #(.W(NPIN)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_sync)
    );

    pinx_fsm #(.BOOT_CYCLES(BOOT_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .boot_done(boot_done)
    );

    pinx_regs #(.NPIN(NPIN), .PRI_PINS(PRI_PINS), .FW_HI(FW_HI), .FW_LO(FW_LO)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .busy(busy), .boot_done(boot_done), .in_sync(in_sync),
        .bus_rdata(bus_rdata), .pri_en(pri_en), .alt_en(alt_en),
        .dir(dir), .typ(typ), .pul(pul), .lat(lat)
    );

    pinx_pad #(.NPIN(NPIN)) u_pad (
        .en(en_vec), .dir(dir), .typ(typ), .pul(pul), .lat(lat),
        .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up)
    );
endmodule

// File: rtl/pinx_core_chk.sv
module pinx_core_chk #(
    parameter int NPIN = 24,
    parameter int PRI_PINS = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            alt_en,
    input logic            addr_sel,
    input logic [7:0]      bus_addr,
    input logic            bus_rd,
    input logic [7:0]      bus_rdata,
    input logic [NPIN-1:0] pad_oe,
    input logic [NPIN-1:0] pad_pull_en,
    input logic [NPIN-1:0] pad_pull_up
);
    // R6: a pulled pin is an input, so it is never driven
    a_r6_pull_not_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_pull_en) == '0);

    // R6: pull polarity only meaningful with the pull enabled
    a_r6_up_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull_up & ~pad_pull_en) == '0);

    // R8: disabled alternate bank is neutral
    a_r8_alt_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_en |-> (pad_oe[NPIN-1:PRI_PINS] == '0 && pad_pull_en[NPIN-1:PRI_PINS] == '0));

    // R9: reads during boot return zero
    a_r9_boot_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_rd) |=> bus_rdata == 8'h00);

    // R9: leaving boot leaves every pin a floating input
    a_r9_clean_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (pad_oe == '0 && pad_pull_en == '0));

    // R2: identity follows the address select
    a_r2_ident: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !busy && bus_addr == 8'h00) |=>
            bus_rdata == ~{6'b100001, $past(addr_sel), 1'b0});
endmodule

bind pinx_core pinx_core_chk #(.NPIN(NPIN), .PRI_PINS(PRI_PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .alt_en(alt_en),
    .addr_sel(addr_sel), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pad_oe(pad_oe), .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up)
);

// File: tb/pinx_core_bench.sv
module pinx_core_bench;
    localparam int BOOT = 16;
    localparam logic [7:0] FWH = 8'h02;
    localparam logic [7:0] FWL = 8'h37;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_sel = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [23:0] pad_in = '0;
    logic [23:0] pad_out, pad_oe, pad_pull_en, pad_pull_up;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pinx_core #(.BOOT_CYCLES(BOOT), .FW_HI(FWH), .FW_LO(FWL)) u_pinx_core (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 oe", pad_oe, 0);
        chk("R1 pull_en", pad_pull_en, 0);
        chk("R1 pull_up", pad_pull_up, 0);
        rd(8'h40, v); chk("R1 sysctl", v, 0);
        rd(8'h60, v); chk("R1 dir", v, 0);
    endtask

    task automatic t_ident();
        logic [7:0] v;
        addr_sel = 1'b0; rd(8'h00, v); chk("R2 id sel0", v, 8'h7B);
        addr_sel = 1'b1; rd(8'h00, v); chk("R2 id sel1", v, 8'h79);
        rd(8'h01, v); chk("R2 fw hi", v, FWH);
        rd(8'h02, v); chk("R2 fw lo", v, FWL);
    endtask

    task automatic t_enable();
        logic [7:0] v;
        wr(8'h40, 8'h09);
        rd(8'h40, v); chk("R8 enables", v, 8'h09);
    endtask

    task automatic t_pushpull();
        logic [7:0] v;
        wr(8'h64, 8'hFF); wr(8'h60, 8'h0F); wr(8'h6C, 8'h05);
        chk("R3 oe", pad_oe[7:0], 8'h0F);
        chk("R3 out", pad_out[7:0], 8'h05);
        wr(8'h6C, 8'h02);
        chk("R4 set keeps", pad_out[7:0], 8'h07);
        wr(8'h70, 8'h01);
        chk("R4 clear", pad_out[7:0], 8'h06);
        rd(8'h6C, v); chk("R4 read set", v, 8'h06);
        rd(8'h70, v); chk("R4 read clr", v, 8'h06);
    endtask

    task automatic t_opendrain();
        wr(8'h61, 8'hFF);
        chk("R5 low drives", pad_oe[15:8], 8'hFF);
        wr(8'h6D, 8'hF0);
        chk("R5 high released", pad_oe[15:8], 8'h0F);
    endtask

    task automatic t_pull();
        wr(8'h66, 8'h0F); wr(8'h6A, 8'h05);
        chk("R6 pull_en", pad_pull_en[23:16], 8'h0F);
        chk("R6 pull_up", pad_pull_up[23:16], 8'h05);
        chk("R6 no drive", pad_oe[23:16], 8'h00);
    endtask

    task automatic t_bank();
        wr(8'h40, 8'h01);
        chk("R8 alt forced", pad_pull_en[23:16], 8'h00);
        chk("R8 pri untouched", pad_oe[7:0], 8'h0F);
        wr(8'h66, 8'h00);
        wr(8'h40, 8'h09);
        chk("R8 write dropped", pad_pull_en[23:16], 8'h0F);
    endtask

    task automatic t_input();
        logic [7:0] v;
        @(negedge clk);
        pad_in = 24'h5AC33C;
        rd(8'h10, v); chk("R7 stale", v, 8'h00);
        rd(8'h10, v); chk("R7 byte0", v, 8'h3C);
        rd(8'h11, v); chk("R7 byte1", v, 8'hC3);
        rd(8'h12, v); chk("R7 byte2", v, 8'h5A);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        wr(8'h63, 8'hFF); rd(8'h63, v); chk("R10 unmapped", v, 8'h00);
        rd(8'h50, v); chk("R10 read 50", v, 8'h00);
        wr(8'h01, 8'h00); rd(8'h01, v); chk("R10 fw ro", v, FWH);
        wr(8'h10, 8'h00); rd(8'h10, v); chk("R10 in ro", v, 8'h3C);
    endtask

    task automatic t_softreset();
        logic [7:0] v;
        wr(8'h40, 8'h89);
        rd(8'h00, v); chk("R9 busy read", v, 8'h00);
        wr(8'h62, 8'hFF);
        repeat (BOOT + 4) @(negedge clk);
        rd(8'h40, v); chk("R9 sysctl cleared", v, 8'h00);
        rd(8'h61, v); chk("R9 dir cleared", v, 8'h00);
        chk("R9 oe", pad_oe, 0);
        chk("R9 pull", pad_pull_en, 0);
        wr(8'h40, 8'h08);
        rd(8'h62, v); chk("R9 boot write dropped", v, 8'h00);
        rd(8'h6E, v); chk("R9 latch cleared", v, 8'h00);
        addr_sel = 1'b0; rd(8'h00, v); chk("R2 id after boot", v, 8'h7B);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ident();
        t_enable();
        t_pushpull();
        t_opendrain();
        t_pull();
        t_bank();
        t_input();
        t_unmapped();
        t_softreset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule